// File: doc/BRIEF.md
# Buffered Indirect Flash Read Controller

This block runs one indirect read from a serial flash at a time. The host programs a start address, a byte count, an instruction word, an address length, a fill watermark and a mode byte through a small word-indexed register port. It then sets the start bit. The controller emits the header of the read as a stream of beats: the opcode, the address bytes, an optional mode byte and an optional dummy-cycle count. It then accepts exactly the programmed number of data bytes from the flash side. The serial pin drivers are modelled as a byte-stream interface, and the flash select output stays high for the whole transfer.

Incoming bytes are packed into words, least significant byte first, and written into a receive FIFO. The host drains the FIFO through a data port. When the FIFO is full the controller stops accepting flash bytes, so no byte is dropped. The flash side sees this as back-pressure on its byte stream. The FIFO fill level can be read in words, and a watermark pin reports when the level exceeds the programmed mark. When the last byte has arrived, in-progress clears and a sticky done flag sets; the host clears the flag by writing one to it. A cancel write aborts the transfer and empties the FIFO.

All three streams use valid/ready handshakes. A beat moves on a rising edge where both valid and ready are high. The header beat held on `fo_*` stays stable until `fo_ready` is seen. The flash byte on `rx_*` is taken only while `rx_ready` is high. `rd_data` holds the oldest word unchanged until `rd_ready` pops it.

Top module: `indirect_read_ctrl`

## Requirements
- R1: Register index 0 is control. Writing it with bit 0 set while idle starts a transfer, and from the next cycle bit 2 reads 1 and `fl_sel` is high. A start written while a transfer runs is ignored. The first beat has phase code 0, carries the opcode from instruction bits 7:0, and uses the lane code from instruction bits 9:8 (0 single, 1 dual, 2 quad).
- R2: After the opcode come the address beats. Register index 4 bits 1:0 hold the address byte count minus one (2 means 3 bytes, 3 means 4 bytes). Address bytes go out most significant first, with phase code 1 and the lane code from instruction bits 13:12. If instruction bit 20 is set, a beat with phase code 2 follows carrying the register index 7 byte. If instruction bits 28:24 are nonzero, a beat with phase code 3 carries that dummy-cycle count. The mode and dummy beats also use the lane code from bits 13:12. Each beat is held stable until `fo_ready`.
- R3: After the header, `rx_ready` is high (unless R5 applies) until exactly the programmed byte count (register index 2) has been taken. Meanwhile `fo_phase` reads 4 and `fo_lanes` reads instruction bits 17:16. Outside this phase `rx_ready` is low.
- R4: Bytes are packed into FIFO words with the first byte in bits 7:0. A final partial word is written with its unused upper bytes zero.
- R5: While the FIFO holds `FIFO_DEPTH` words, `rx_ready` is low. Every accepted byte appears exactly once in the output words.
- R6: Register index 6 bits 15:0 read the number of words in the FIFO. `wm_reached` is high when this level is greater than register index 5 bits 15:0.
- R7: `rd_valid` is high whenever the FIFO is not empty, and `rd_data` is the oldest word. The word is removed on a cycle where `rd_valid` and `rd_ready` are both high, and otherwise stays unchanged.
- R8: On the edge that takes the last byte, control bit 2 clears and control bit 5 (done) sets. Done stays set through writes that have bit 5 clear. Writing a one to bit 5 clears it, and a new start also clears it.
- R9: Writing control bit 1 during a transfer ends it at that edge. In-progress goes low, the FIFO and the partial word are emptied (level 0, `rd_valid` low), and done stays clear.
- R10: Writes to register indices 1 to 5 and 7 are ignored while a transfer runs, and a readback returns the earlier value.
- R11: With a byte count of zero, the transfer ends on the edge that takes the last header beat. Done sets, and no byte or word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| fl_sel | output | 1 | Flash select, high while a transfer runs |
| fo_valid | output | 1 | Header beat valid |
| fo_ready | input | 1 | Header beat accepted by the pin driver |
| fo_phase | output | 3 | Phase code: 0 opcode, 1 address, 2 mode, 3 dummy, 4 data, 5 idle |
| fo_lanes | output | 2 | Lane code of the current phase |
| fo_byte | output | 8 | Header beat byte (dummy count for phase 3) |
| rx_valid | input | 1 | Flash data byte valid |
| rx_ready | output | 1 | Controller can take a flash byte |
| rx_byte | input | 8 | Flash data byte |
| rd_valid | output | 1 | Receive FIFO word available |
| rd_ready | input | 1 | Host pops the word |
| rd_data | output | 8*WORD_BYTES | Oldest receive FIFO word |
| wm_reached | output | 1 | Fill level above watermark |

## Verification
Every register and stream result is due one clock edge after its cause. A control write or accepted beat changes the status bits and the next header beat after that edge. The edge that takes the last byte moves in-progress, done and the FIFO level together. A cancel has emptied the FIFO by the following cycle. Reads of `reg_rdata` are combinational on the current index. The bench drives inputs just after the falling edge and then compares every output with a behavioural queue model. It then advances that model by one cycle using the same handshakes, so each comparison falls in the cycle where the result is due. The model checks the R5 stall, the R4 padded tail word, cancel, and a zero-length transfer in separate scenarios.

// File: rtl/irc_pkg.sv
package irc_pkg;

  // Register word indices; control is fixed at 0 because software pokes it bitwise.
  localparam logic [2:0] RIX_CTRL  = 3'd0;
  localparam logic [2:0] RIX_ADDR  = 3'd1;
  localparam logic [2:0] RIX_COUNT = 3'd2;
  localparam logic [2:0] RIX_INSTR = 3'd3;
  localparam logic [2:0] RIX_ALEN  = 3'd4;
  localparam logic [2:0] RIX_WMARK = 3'd5;
  localparam logic [2:0] RIX_LEVEL = 3'd6;
  localparam logic [2:0] RIX_MODE  = 3'd7;

  // Control bits
  localparam int CB_START  = 0;
  localparam int CB_CANCEL = 1;
  localparam int CB_BUSY   = 2;
  localparam int CB_DONE   = 5;

  // Phase codes on the header stream
  localparam logic [2:0] PH_OPC  = 3'd0;
  localparam logic [2:0] PH_ADR  = 3'd1;
  localparam logic [2:0] PH_MOD  = 3'd2;
  localparam logic [2:0] PH_DMY  = 3'd3;
  localparam logic [2:0] PH_DAT  = 3'd4;
  localparam logic [2:0] PH_IDLE = 3'd5;

  typedef enum logic [2:0] {
    S_IDLE, S_OPC, S_ADR, S_MOD, S_DMY, S_DAT
  } seq_st_e;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] count;
    logic [7:0]  opcode;
    logic [1:0]  ilane;
    logic [1:0]  alane;
    logic [1:0]  dlane;
    logic        mode_en;
    logic [4:0]  dummy;
    logic [1:0]  alen;
    logic [7:0]  mode;
  } xfer_cfg_t;

endpackage

// File: rtl/irc_regs.sv
module irc_regs
  import irc_pkg::*;
#(
  parameter int LEVEL_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               seq_busy,
  input  logic               seq_done,
  input  logic [LEVEL_W-1:0] level,
  output xfer_cfg_t          cfg,
  output logic               start_p,
  output logic               cancel_p,
  output logic               wm_reached
);

  logic        done_q;
  logic [15:0] wmark_q;
  logic        ctrl_wr;
  logic [15:0] level16;

  assign ctrl_wr  = reg_we && (reg_addr == RIX_CTRL);
  assign start_p  = ctrl_wr && reg_wdata[CB_START]  && !seq_busy;
  assign cancel_p = ctrl_wr && reg_wdata[CB_CANCEL] && seq_busy;
  assign level16  = 16'(level);
  assign wm_reached = level16 > wmark_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg     <= '0;
      wmark_q <= '0;
    end else if (reg_we && !seq_busy) begin
      unique case (reg_addr)
        RIX_ADDR:  cfg.addr  <= reg_wdata;
        RIX_COUNT: cfg.count <= reg_wdata;
        RIX_INSTR: begin
          cfg.opcode  <= reg_wdata[7:0];
          cfg.ilane   <= reg_wdata[9:8];
          cfg.alane   <= reg_wdata[13:12];
          cfg.dlane   <= reg_wdata[17:16];
          cfg.mode_en <= reg_wdata[20];
          cfg.dummy   <= reg_wdata[28:24];
        end
        RIX_ALEN:  cfg.alen  <= reg_wdata[1:0];
        RIX_WMARK: wmark_q   <= reg_wdata[15:0];
        RIX_MODE:  cfg.mode  <= reg_wdata[7:0];
        default: ;
      endcase
    end
  end

  // Sticky completion: start clears, completion sets, write-one clears.
  always_ff @(posedge clk) begin
    if (!rst_n)                               done_q <= 1'b0;
    else if (start_p)                         done_q <= 1'b0;
    else if (seq_done)                        done_q <= 1'b1;
    else if (ctrl_wr && reg_wdata[CB_DONE])   done_q <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RIX_CTRL: begin
        reg_rdata[CB_BUSY] = seq_busy;
        reg_rdata[CB_DONE] = done_q;
      end
      RIX_ADDR:  reg_rdata = cfg.addr;
      RIX_COUNT: reg_rdata = cfg.count;
      RIX_INSTR: begin
        reg_rdata[7:0]   = cfg.opcode;
        reg_rdata[9:8]   = cfg.ilane;
        reg_rdata[13:12] = cfg.alane;
        reg_rdata[17:16] = cfg.dlane;
        reg_rdata[20]    = cfg.mode_en;
        reg_rdata[28:24] = cfg.dummy;
      end
      RIX_ALEN:  reg_rdata[1:0]  = cfg.alen;
      RIX_WMARK: reg_rdata[15:0] = wmark_q;
      RIX_LEVEL: reg_rdata[15:0] = level16;
      RIX_MODE:  reg_rdata[7:0]  = cfg.mode;
      default: ;
    endcase
  end

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !seq_busy);

  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |=> ($stable(cfg) && $stable(wmark_q)));

endmodule

// File: rtl/irc_seq.sv
module irc_seq
  import irc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  xfer_cfg_t  cfg,
  input  logic       start,
  input  logic       cancel,
  input  logic       fifo_full,
  input  logic       fo_ready,
  input  logic       rx_valid,
  output logic       fo_valid,
  output logic [2:0] fo_phase,
  output logic [1:0] fo_lanes,
  output logic [7:0] fo_byte,
  output logic       rx_ready,
  output logic       rx_take,
  output logic       rx_last,
  output logic       busy,
  output logic       done_p
);

  seq_st_e    state, hdr_next, st_tail, st_post_mod, st_post_adr;
  logic [1:0] cnt;
  logic [CNT_W-1:0] remain;
  logic       beat_acc;

  always_comb begin
    st_tail     = (cfg.count != '0) ? S_DAT : S_IDLE;
    st_post_mod = (cfg.dummy != '0) ? S_DMY : st_tail;
    st_post_adr = cfg.mode_en ? S_MOD : st_post_mod;
    hdr_next    = state;
    unique case (state)
      S_OPC: hdr_next = S_ADR;
      S_ADR: hdr_next = (cnt == 2'd0) ? st_post_adr : S_ADR;
      S_MOD: hdr_next = st_post_mod;
      S_DMY: hdr_next = st_tail;
      default: hdr_next = state;
    endcase
  end

  always_comb begin
    fo_byte  = '0;
    fo_lanes = '0;
    fo_phase = PH_IDLE;
    unique case (state)
      S_OPC: begin fo_phase = PH_OPC; fo_byte = cfg.opcode; fo_lanes = cfg.ilane; end
      S_ADR: begin fo_phase = PH_ADR; fo_byte = cfg.addr[{cnt, 3'b000} +: 8]; fo_lanes = cfg.alane; end
      S_MOD: begin fo_phase = PH_MOD; fo_byte = cfg.mode; fo_lanes = cfg.alane; end
      S_DMY: begin fo_phase = PH_DMY; fo_byte = {3'b000, cfg.dummy}; fo_lanes = cfg.alane; end
      S_DAT: begin fo_phase = PH_DAT; fo_lanes = cfg.dlane; end
      default: ;
    endcase
  end

  assign fo_valid = (state == S_OPC) || (state == S_ADR) || (state == S_MOD) || (state == S_DMY);
  assign busy     = (state != S_IDLE);
  assign beat_acc = fo_valid && fo_ready;
  assign rx_ready = (state == S_DAT) && !fifo_full;
  assign rx_take  = rx_valid && rx_ready;
  assign rx_last  = (remain == CNT_W'(1));
  assign done_p   = !cancel && ((beat_acc && hdr_next == S_IDLE) || (rx_take && rx_last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      remain <= '0;
    end else if (cancel) begin
      state <= S_IDLE;
    end else if (start) begin
      state <= S_OPC;
      cnt   <= cfg.alen;
    end else begin
      if (beat_acc) begin
        state <= hdr_next;
        if (state == S_ADR) cnt <= cnt - 2'd1;
        if (hdr_next == S_DAT) remain <= CNT_W'(cfg.count);
      end
      if (rx_take) begin
        remain <= remain - CNT_W'(1);
        if (rx_last) state <= S_IDLE;
      end
    end
  end

  assert_beat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fo_valid && !fo_ready && !cancel) |=> (fo_valid && $stable(fo_byte) && $stable(fo_phase)));

  assert_remain_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DAT) |-> (remain != '0));

  assert_cancel_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !busy);

endmodule

// File: rtl/irc_pack.sv
module irc_pack #(
  parameter int WORD_BYTES = 4,
  localparam int WORD_W = 8 * WORD_BYTES,
  localparam int IDX_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [7:0]        in_byte,
  input  logic              last,
  input  logic              flush,
  output logic              push,
  output logic [WORD_W-1:0] push_word
);

  logic [WORD_W-1:0] acc_q;
  logic [IDX_W-1:0]  idx_q;

  always_comb begin
    for (int i = 0; i < WORD_BYTES; i++) begin
      push_word[i*8 +: 8] = (idx_q == IDX_W'(i)) ? in_byte : acc_q[i*8 +: 8];
    end
  end

  assign push = take && !flush && ((idx_q == IDX_W'(WORD_BYTES - 1)) || last);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (take) begin
      if (push) begin
        acc_q <= '0;   // zero so the next tail word is padded
        idx_q <= '0;
      end else begin
        acc_q <= push_word;
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  assert_tail_pushed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !flush && !push) |=> (idx_q != '0));

endmodule

// File: rtl/irc_rxfifo.sv
module irc_rxfifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_word,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic [CNT_W-1:0] level
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign rd_valid = (level != '0);
  assign full     = (level == CNT_W'(DEPTH));
  assign rd_data  = mem[rptr];
  assign pop      = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      unique case ({push, pop})
        2'b10:   level <= level + CNT_W'(1);
        2'b01:   level <= level - CNT_W'(1);
        default: ;
      endcase
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH));

  assert_word_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !flush) |=> (rd_valid && $stable(rd_data)));

endmodule

// File: rtl/indirect_read_ctrl.sv
module indirect_read_ctrl
  import irc_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int WORD_BYTES = 4,
  localparam int WORD_W  = 8 * WORD_BYTES,
  localparam int LEVEL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              fl_sel,
  output logic              fo_valid,
  input  logic              fo_ready,
  output logic [2:0]        fo_phase,
  output logic [1:0]        fo_lanes,
  output logic [7:0]        fo_byte,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_byte,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_data,
  output logic              wm_reached
);

  xfer_cfg_t          cfg;
  logic               start_p, cancel_p, seq_busy, seq_done;
  logic               rx_take, rx_last, fifo_full, push;
  logic [WORD_W-1:0]  push_word;
  logic [LEVEL_W-1:0] level;

  assign fl_sel = seq_busy;

  irc_regs #(.LEVEL_W(LEVEL_W)) u_regs (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .seq_busy, .seq_done, .level, .cfg, .start_p, .cancel_p, .wm_reached
  );

  irc_seq #(.CNT_W(32)) u_seq (
    .clk, .rst_n, .cfg, .start(start_p), .cancel(cancel_p), .fifo_full,
    .fo_ready, .rx_valid, .fo_valid, .fo_phase, .fo_lanes, .fo_byte,
    .rx_ready, .rx_take, .rx_last, .busy(seq_busy), .done_p(seq_done)
  );

  irc_pack #(.WORD_BYTES(WORD_BYTES)) u_pack (
    .clk, .rst_n, .take(rx_take), .in_byte(rx_byte), .last(rx_last),
    .flush(cancel_p), .push, .push_word
  );

  irc_rxfifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_fifo (
    .clk, .rst_n, .flush(cancel_p), .push, .push_word,
    .rd_valid, .rd_ready, .rd_data, .full(fifo_full), .level
  );

endmodule

// File: tb/indirect_read_ctrl_tb_top.sv
module indirect_read_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int WB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fl_sel, fo_valid, rx_ready, rd_valid, wm_reached;
  logic        fo_ready = 1'b0, rx_valid = 1'b0, rd_ready = 1'b0;
  logic [2:0]  fo_phase;
  logic [1:0]  fo_lanes;
  logic [7:0]  fo_byte;
  logic [7:0]  rx_byte = '0;
  logic [31:0] rd_data;

  indirect_read_ctrl #(.FIFO_DEPTH(DEPTH), .WORD_BYTES(WB)) dut_i (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .fl_sel,
    .fo_valid, .fo_ready, .fo_phase, .fo_lanes, .fo_byte,
    .rx_valid, .rx_ready, .rx_byte, .rd_valid, .rd_ready, .rd_data, .wm_reached
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int bcyc = 0;

  // Reference model state
  bit [31:0] mreg [8];
  bit        mbusy = 0, mdone = 0;
  bit [12:0] hq [$];          // {phase, lanes, byte}
  int unsigned mrem = 0;
  bit [31:0] mfifo [$];
  bit [31:0] mpart = 0;
  int        mpidx = 0;
  int        src_k = 0;

  // Drive controls
  bit        d_we = 0;
  bit [2:0]  d_addr = 0;
  bit [31:0] d_wdata = 0;
  int        fo_pat = 0, rx_pat = 0, rd_pat = 0;

  function automatic bit [7:0] src_byte(int k);
    return 8'(k * 37 + 11);
  endfunction

  function automatic bit pat_on(int p, int c);
    case (p)
      0: return 1'b1;
      1: return (c % 2) == 0;
      2: return 1'b0;
      default: return (c % 3) != 0;
    endcase
  endfunction

  function automatic bit [31:0] mread(bit [2:0] a);
    case (a)
      3'd0: return (32'(mbusy) << 2) | (32'(mdone) << 5);
      3'd6: return 32'(mfifo.size());
      default: return mreg[a];
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, bcyc);
    end
  endtask

  task automatic compare();
    bit fov, rxr;
    fov = mbusy && hq.size() > 0;
    rxr = mbusy && hq.size() == 0 && mfifo.size() < DEPTH;
    chk("R1 fl_sel", 32'(fl_sel), 32'(mbusy));
    chk("R2 fo_valid", 32'(fo_valid), 32'(fov));
    if (fov) begin
      chk("R1 R2 fo_phase", 32'(fo_phase), 32'(hq[0][12:10]));
      chk("R1 R2 fo_lanes", 32'(fo_lanes), 32'(hq[0][9:8]));
      chk("R1 R2 fo_byte", 32'(fo_byte), 32'(hq[0][7:0]));
    end
    chk("R3 R5 rx_ready", 32'(rx_ready), 32'(rxr));
    if (mbusy && hq.size() == 0) begin
      chk("R3 data phase code", 32'(fo_phase), 32'd4);
      chk("R3 data lanes", 32'(fo_lanes), 32'(mreg[3][17:16]));
    end
    chk("R7 rd_valid", 32'(rd_valid), 32'(mfifo.size() > 0));
    if (mfifo.size() > 0) chk("R4 R7 rd_data", rd_data, mfifo[0]);
    chk("R6 wm_reached", 32'(wm_reached), 32'(mfifo.size() > mreg[5]));
    chk("R6 R8 R10 readback", reg_rdata, mread(d_addr));
  endtask

  task automatic model_step(bit a_fo, bit a_rx, bit [7:0] a_byte, bit a_rd);
    bit fov, rxr, rdv, foa, rxa, pop, ctrl, st, cn, clr, sdone, pb;
    fov = mbusy && hq.size() > 0;
    rxr = mbusy && hq.size() == 0 && mfifo.size() < DEPTH;
    rdv = mfifo.size() > 0;
    foa = fov && a_fo; rxa = rxr && a_rx; pop = rdv && a_rd;
    ctrl = d_we && d_addr == 3'd0;
    st = ctrl && d_wdata[0] && !mbusy;
    cn = ctrl && d_wdata[1] && mbusy;
    clr = ctrl && d_wdata[5];
    sdone = 0; pb = mbusy;
    if (rxa) src_k++;
    if (cn) begin
      mbusy = 0; mfifo.delete(); mpart = 0; mpidx = 0;
    end else begin
      if (pop) void'(mfifo.pop_front());
      if (foa) begin
        void'(hq.pop_front());
        if (hq.size() == 0 && mrem == 0) begin mbusy = 0; sdone = 1; end
      end
      if (rxa) begin
        mpart |= 32'(a_byte) << (8 * mpidx);
        mrem--;
        if (mpidx == WB - 1 || mrem == 0) begin
          mfifo.push_back(mpart); mpart = 0; mpidx = 0;
        end else mpidx++;
        if (mrem == 0) begin mbusy = 0; sdone = 1; end
      end
      if (st) begin
        hq.delete();
        hq.push_back({3'd0, mreg[3][9:8], mreg[3][7:0]});
        for (int i = int'(mreg[4][1:0]); i >= 0; i--)
          hq.push_back({3'd1, mreg[3][13:12], mreg[1][8*i +: 8]});
        if (mreg[3][20]) hq.push_back({3'd2, mreg[3][13:12], mreg[7][7:0]});
        if (mreg[3][28:24] != 0) hq.push_back({3'd3, mreg[3][13:12], 3'b000, mreg[3][28:24]});
        mrem = mreg[2]; mbusy = 1;
      end
    end
    if (st) mdone = 0;
    else if (sdone) mdone = 1;
    else if (clr) mdone = 0;
    if (d_we && !pb) begin
      case (d_addr)
        3'd1, 3'd2: mreg[d_addr] = d_wdata;
        3'd3: mreg[3] = d_wdata & 32'h1F13_33FF;
        3'd4: mreg[4] = d_wdata & 32'h3;
        3'd5: mreg[5] = d_wdata & 32'hFFFF;
        3'd7: mreg[7] = d_wdata & 32'hFF;
        default: ;
      endcase
    end
  endtask

  task automatic tick();
    bit a_fo, a_rx, a_rd;
    bit [7:0] a_byte;
    @(negedge clk);
    bcyc++;
    a_fo = pat_on(fo_pat, bcyc);
    a_rx = pat_on(rx_pat, bcyc);
    a_rd = pat_on(rd_pat, bcyc);
    a_byte = src_byte(src_k);
    reg_we = d_we; reg_addr = d_addr; reg_wdata = d_wdata;
    fo_ready = a_fo; rx_valid = a_rx; rx_byte = a_byte; rd_ready = a_rd;
    #1;
    compare();
    model_step(a_fo, a_rx, a_byte, a_rd);
    if (d_we) begin d_we = 0; d_addr = 0; end
  endtask

  task automatic wr(bit [2:0] a, bit [31:0] v);
    d_we = 1; d_addr = a; d_wdata = v;
    tick();
  endtask

  // Ticks with a read index selected; reg_rdata sampled before the edge.
  task automatic probe(bit [2:0] a, bit [31:0] exp, string tag);
    d_addr = a;
    tick();
    chk(tag, reg_rdata, exp);
    d_addr = 0;
  endtask

  task automatic run(int n);
    repeat (n) tick();
  endtask

  task automatic wait_idle(int cap);
    int i = 0;
    while (mbusy && i < cap) begin tick(); i++; end
    chk("R8 transfer completes", 32'(mbusy), 32'd0);
  endtask

  task automatic setup(bit [31:0] addr, bit [31:0] cnt, bit [31:0] instr,
                       bit [1:0] alen, bit [7:0] mode, bit [15:0] wm);
    wr(3'd1, addr); wr(3'd2, cnt); wr(3'd3, instr);
    wr(3'd4, 32'(alen)); wr(3'd7, 32'(mode)); wr(3'd5, 32'(wm));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mreg[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    run(2);
    probe(3'd0, 32'h0, "R1 reset control idle");
    probe(3'd6, 32'h0, "R6 reset level zero");

    // T1: single-lane header, 3-byte address, 8 dummy cycles, quad data, 10 bytes
    fo_pat = 0; rx_pat = 3; rd_pat = 2;
    setup(32'h0012_3456, 32'd10, 32'h0802_006B, 2'd2, 8'h00, 16'd1);
    wr(3'd0, 32'h1);
    probe(3'd0, 32'h4, "R1 in-progress after start");
    wait_idle(200);
    probe(3'd0, 32'h20, "R8 done after last byte");
    probe(3'd6, 32'd3, "R4 three words for ten bytes");
    rd_pat = 0; run(6);
    chk("R7 drained", 32'(rd_valid), 32'd0);

    // Done is sticky until written with one
    wr(3'd0, 32'h0);
    probe(3'd0, 32'h20, "R8 done held by zero write");
    wr(3'd0, 32'h20);
    probe(3'd0, 32'h0, "R8 done cleared by write one");

    // T2: dual header, 4-byte address, mode byte, no dummy, 41 bytes, stall on full
    fo_pat = 1; rx_pat = 0; rd_pat = 2;
    setup(32'hA1B2_C3D4, 32'd41, 32'h0012_11EB, 2'd3, 8'hA5, 16'd5);
    wr(3'd0, 32'h1);
    run(60);
    probe(3'd6, 32'd8, "R5 fifo full level");
    chk("R5 stalled rx_ready", 32'(rx_ready), 32'd0);
    wr(3'd1, 32'hDEAD_BEEF);
    wr(3'd0, 32'h1);
    probe(3'd1, 32'hA1B2_C3D4, "R10 write while busy ignored");
    rd_pat = 3;
    wait_idle(400);
    rd_pat = 0; run(14);
    chk("R4 R7 all words out", 32'(rd_valid), 32'd0);

    // T5: start clears done
    setup(32'h0000_0100, 32'd3, 32'h0000_0003, 2'd2, 8'h00, 16'd0);
    wr(3'd0, 32'h1);
    probe(3'd0, 32'h4, "R8 start clears done");
    wait_idle(100);
    run(4);

    // T3: cancel with data buffered
    fo_pat = 0; rx_pat = 0; rd_pat = 2;
    setup(32'h0040_0000, 32'd100, 32'h0501_003B, 2'd2, 8'h00, 16'd2);
    wr(3'd0, 32'h1);
    run(30);
    wr(3'd0, 32'h2);
    probe(3'd6, 32'd0, "R9 level after cancel");
    probe(3'd0, 32'h0, "R9 idle without done");
    chk("R9 nothing to drain", 32'(rd_valid), 32'd0);

    // T4: zero byte count
    rd_pat = 0;
    setup(32'h0000_0010, 32'd0, 32'h0000_0003, 2'd2, 8'h00, 16'd0);
    wr(3'd0, 32'h1);
    wait_idle(50);
    probe(3'd0, 32'h20, "R11 done with zero count");
    probe(3'd6, 32'h0, "R11 no word written");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule